// File: doc/BRIEF.md
# UART Line Status Flag Logic

This block derives the line status flags of a 16550-style UART whose transmitter and receiver each own an optional 16-entry FIFO. The flag logic sees only events: host writes to the transmit holding register, hand-offs from the holding register to the shift register, the shift register busy level, the transmit FIFO fill count, the raw receive line, a once-per-bit tick, and error tags on entries entering and leaving the receive FIFO. From these it produces holding-register-empty, transmitter-empty, break and a receive FIFO error summary.

Break detection counts bit ticks while the receive line is low. The frame length comes from the configured word length, parity enable and stop-bit count. Each break event asks the receive FIFO to store one break character through a single-cycle request. The detector then stays disarmed until the line returns to mark. The error summary is a counter of tagged entries currently stored, so the flag follows entries as they enter and leave the FIFO.

Top module: `uart_line_status`

## Requirements
- R1: With `fifo_en`=0, `thre` resets to 1. It reads 0 combinationally in any cycle where `thr_wr`=1 and stays 0 after the write. It returns to 1 in the cycle after a `thr_to_tsr` edge that has no concurrent write.
- R2: With `fifo_en`=1, `thre` is 1 exactly when `tx_fifo_count` is 0.
- R3: `temt` is 1 only when `thre` is 1 and `tsr_busy` is 0. It is 0 whenever either of the two holds a character.
- R4: The break frame length in ticks is 7 + `wlen` + `par_en` + `stop2`. `wlen` 0..3 selects 5..8 data bits, and `stop2`=1 selects two stop bits. `brk_flag` rises at the clock edge that samples the frame-length-th consecutive `bit_tick` with `rx_line`=0. The `rx_line`=0 ticks before it leave the flag at 0.
- R5: `brk_push` is a one-cycle pulse issued in the same cycle that `brk_flag` rises. A single break event issues exactly one pulse, however many ticks the line then stays low.
- R6: Once set, `brk_flag` stays 1 while `rx_line`=0. It clears at the first edge that samples `rx_line`=1.
- R7: After a break, a new break needs the line to return to 1 and then stay low for a full frame again.
- R8: A cycle with `rx_line`=1 clears the partial low count, so a low period interrupted by mark before a full frame raises no break.
- R9: `rx_fifo_err` is 1 from the edge after a tagged entry is stored (`rx_push`&`rx_push_err`, or `brk_push`). It clears at the edge where the last tagged entry leaves (`rx_pop`&`rx_pop_err`). A tagged push and a tagged pop in the same cycle leave it unchanged, and untagged pushes have no effect.
- R10: After reset `brk_flag`=0, `rx_fifo_err`=0, `brk_push`=0, and `thre`=`temt`=1 when no byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects FIFO mode |
| thr_wr | input | 1 | Host write to the transmit holding register |
| thr_to_tsr | input | 1 | Holding register moved into the shift register |
| tsr_busy | input | 1 | Shift register holds a character |
| tx_fifo_count | input | 5 | Transmit FIFO fill level |
| rx_line | input | 1 | Receive line level, mark = 1 |
| bit_tick | input | 1 | One pulse per bit time |
| wlen | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| rx_push | input | 1 | Entry written into the receive FIFO |
| rx_push_err | input | 1 | That entry carries a parity or framing error |
| rx_pop | input | 1 | Entry read from the receive FIFO |
| rx_pop_err | input | 1 | That entry carried an error or break tag |
| brk_push | output | 1 | Request to store one break character |
| thre | output | 1 | Holding register / transmit FIFO empty |
| temt | output | 1 | Holding side and shift register both empty |
| brk_flag | output | 1 | Break condition present |
| rx_fifo_err | output | 1 | At least one tagged entry in the receive FIFO |

## Verification
The bench walks a table of line configurations and checks that the break appears on exactly the computed tick, not one tick early or late. An off-by-one frame formula would miss this boundary. It then holds the line low for many more ticks and counts break requests. A detector that re-arms without mark would push a second character. A low run broken by a single mark cycle checks that the partial count restarts. Mixed tagged pushes and pops, including both in one cycle, expose an error summary that is sticky or miscounted. The holding-register checks look for the flag dropping in the write cycle itself rather than one cycle later.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  localparam int unsigned LSR_MAX_DATA = 8;
  localparam int unsigned LSR_MAX_FRAME = 1 + LSR_MAX_DATA + 1 + 2;

  // ticks in one character frame: start + data + parity + stop(s)
  function automatic int unsigned lsr_frame_ticks(input logic [1:0] wl,
                                                  input logic par,
                                                  input logic two_stop);
    int unsigned n;
    n = 1 + (5 + int'(wl)) + int'(par) + 1 + int'(two_stop);
    return n;
  endfunction

  // next tagged-entry count
  function automatic int unsigned lsr_err_next(input int unsigned cnt,
                                               input logic inc_a,
                                               input logic inc_b,
                                               input logic dec);
    int n;
    n = int'(cnt) + int'(inc_a) + int'(inc_b) - int'(dec);
    if (n < 0) n = 0;
    return int'(n);
  endfunction

endpackage

// File: rtl/lsr_tx_flags.sv
module lsr_tx_flags #(
  parameter int unsigned TX_DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             thr_wr,
  input  logic             thr_to_tsr,
  input  logic             tsr_busy,
  input  logic [CNT_W-1:0] tx_fifo_count,
  output logic             thre,
  output logic             temt
);

  logic hold_empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_empty_q <= 1'b1;
    else if (thr_wr)     hold_empty_q <= 1'b0;
    else if (thr_to_tsr) hold_empty_q <= 1'b1;
  end

  logic thre_byte;
  logic thre_fifo;

  assign thre_byte = hold_empty_q && !thr_wr;
  assign thre_fifo = (tx_fifo_count == '0);
  assign thre      = fifo_en ? thre_fifo : thre_byte;
  assign temt      = thre && !tsr_busy;

endmodule

// File: rtl/lsr_break_det.sv
module lsr_break_det
  import lsr_pkg::*;
#(
  localparam int unsigned LOW_W = $clog2(LSR_MAX_FRAME + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       bit_tick,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       stop2,
  output logic       brk_hit,
  output logic       brk_flag,
  output logic       brk_push
);

  logic [LOW_W-1:0] low_cnt;
  logic             armed;
  logic [LOW_W-1:0] frame_len;

  assign frame_len = LOW_W'(lsr_frame_ticks(wlen, par_en, stop2));
  assign brk_hit   = armed && !rx_line && bit_tick
                     && (low_cnt == frame_len - LOW_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      armed    <= 1'b1;
      brk_flag <= 1'b0;
      brk_push <= 1'b0;
    end else begin
      brk_push <= brk_hit;
      if (rx_line) begin
        low_cnt  <= '0;
        armed    <= 1'b1;
        brk_flag <= 1'b0;
      end else if (brk_hit) begin
        low_cnt  <= '0;
        armed    <= 1'b0;
        brk_flag <= 1'b1;
      end else if (armed && bit_tick) begin
        low_cnt  <= low_cnt + LOW_W'(1);
      end
    end
  end

endmodule

// File: rtl/lsr_rx_err_sum.sv
module lsr_rx_err_sum
  import lsr_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16,
  localparam int unsigned ERR_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_in_a,
  input  logic             tag_in_b,
  input  logic             tag_out,
  output logic [ERR_W-1:0] err_cnt,
  output logic             rx_fifo_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_cnt <= '0;
    else        err_cnt <= ERR_W'(lsr_err_next(int'(err_cnt), tag_in_a, tag_in_b, tag_out));
  end

  assign rx_fifo_err = (err_cnt != '0);

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status #(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(TX_DEPTH + 1),
  localparam int unsigned ERR_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             thr_wr,
  input  logic             thr_to_tsr,
  input  logic             tsr_busy,
  input  logic [CNT_W-1:0] tx_fifo_count,
  input  logic             rx_line,
  input  logic             bit_tick,
  input  logic [1:0]       wlen,
  input  logic             par_en,
  input  logic             stop2,
  input  logic             rx_push,
  input  logic             rx_push_err,
  input  logic             rx_pop,
  input  logic             rx_pop_err,
  output logic             brk_push,
  output logic             thre,
  output logic             temt,
  output logic             brk_flag,
  output logic             rx_fifo_err
);

  logic             brk_hit;
  logic             tag_push;
  logic             tag_pop;
  logic [ERR_W-1:0] err_cnt;

  assign tag_push = rx_push && rx_push_err;
  assign tag_pop  = rx_pop && rx_pop_err;

  lsr_tx_flags #(.TX_DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_wr(thr_wr),
    .thr_to_tsr(thr_to_tsr), .tsr_busy(tsr_busy),
    .tx_fifo_count(tx_fifo_count), .thre(thre), .temt(temt)
  );

  lsr_break_det u_brk (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
    .wlen(wlen), .par_en(par_en), .stop2(stop2), .brk_hit(brk_hit),
    .brk_flag(brk_flag), .brk_push(brk_push)
  );

  lsr_rx_err_sum #(.RX_DEPTH(RX_DEPTH)) u_err (
    .clk(clk), .rst_n(rst_n), .tag_in_a(tag_push), .tag_in_b(brk_push),
    .tag_out(tag_pop), .err_cnt(err_cnt), .rx_fifo_err(rx_fifo_err)
  );

endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk #(
  parameter int unsigned RX_DEPTH = 16,
  localparam int unsigned ERR_W = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             thr_wr,
  input logic             thr_to_tsr,
  input logic [4:0]       tx_fifo_count,
  input logic             tsr_busy,
  input logic             rx_line,
  input logic             tag_push,
  input logic             tag_pop,
  input logic             brk_push,
  input logic             thre,
  input logic             temt,
  input logic             brk_flag,
  input logic             rx_fifo_err,
  input logic [ERR_W-1:0] err_cnt
);

  AST_THRE_SET_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && thr_to_tsr && !thr_wr) |=> (fifo_en || thr_wr || thre)); // R1
  AST_THRE_FIFO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && tx_fifo_count != '0) |-> !thre); // R2
  AST_TEMT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    temt |-> (thre && !tsr_busy)); // R3
  AST_PUSH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_push |-> (brk_flag && !$past(brk_flag))); // R5
  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !rx_line) |=> brk_flag); // R6
  AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_line |=> !brk_flag); // R6
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_push && !tag_pop) |=> rx_fifo_err); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(err_cnt) <= RX_DEPTH + 1)); // R9

endmodule

bind uart_line_status uart_line_status_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_wr(thr_wr),
  .thr_to_tsr(thr_to_tsr), .tx_fifo_count(tx_fifo_count), .tsr_busy(tsr_busy),
  .rx_line(rx_line), .tag_push(tag_push), .tag_pop(tag_pop),
  .brk_push(brk_push), .thre(thre), .temt(temt), .brk_flag(brk_flag),
  .rx_fifo_err(rx_fifo_err), .err_cnt(err_cnt)
);

// File: tb/tb_uart_line_status.sv
module tb_uart_line_status;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, thr_wr = 0, thr_to_tsr = 0, tsr_busy = 0;
  logic [4:0] tx_fifo_count = '0;
  logic rx_line = 1, bit_tick = 0, par_en = 0, stop2 = 0;
  logic [1:0] wlen = '0;
  logic rx_push = 0, rx_push_err = 0, rx_pop = 0, rx_pop_err = 0;
  logic brk_push, thre, temt, brk_flag, rx_fifo_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_line_status dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_wr(thr_wr),
    .thr_to_tsr(thr_to_tsr), .tsr_busy(tsr_busy), .tx_fifo_count(tx_fifo_count),
    .rx_line(rx_line), .bit_tick(bit_tick), .wlen(wlen), .par_en(par_en),
    .stop2(stop2), .rx_push(rx_push), .rx_push_err(rx_push_err),
    .rx_pop(rx_pop), .rx_pop_err(rx_pop_err), .brk_push(brk_push),
    .thre(thre), .temt(temt), .brk_flag(brk_flag), .rx_fifo_err(rx_fifo_err)
  );

  // {wlen[7:6], par[5], stop2[4], frame ticks[3:0]}
  localparam logic [7:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 4'd7},
    {2'd3, 1'b0, 1'b0, 4'd10},
    {2'd3, 1'b1, 1'b0, 4'd11},
    {2'd3, 1'b1, 1'b1, 4'd12},
    {2'd1, 1'b1, 1'b0, 4'd9},
    {2'd2, 1'b0, 1'b1, 4'd10}
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick();
    bit_tick = 1;
    step();
    bit_tick = 0;
  endtask

  task automatic pop_tagged();
    rx_pop = 1; rx_pop_err = 1;
    step();
    rx_pop = 0; rx_pop_err = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    // R10 reset state
    check("R10 thre", thre, 1);
    check("R10 temt", temt, 1);
    check("R10 brk_flag", brk_flag, 0);
    check("R10 rx_fifo_err", rx_fifo_err, 0);
    check("R10 brk_push", brk_push, 0);

    // table walk: frame length per configuration (R4, R5, R6, R7)
    for (int v = 0; v < 6; v++) begin
      int unsigned n;
      int pushes;
      {wlen, par_en, stop2} = VEC[v][7:4];
      n = VEC[v][3:0];
      rx_line = 1; step();
      rx_line = 0;
      for (int k = 0; k < int'(n) - 1; k++) tick();
      check("R4 no early break", brk_flag, 0);
      bit_tick = 1;
      step();
      bit_tick = 0;
      check("R4 break on frame tick", brk_flag, 1);
      check("R5 push pulse", brk_push, 1);
      step();
      check("R5 pulse width", brk_push, 0);
      check("R9 break tags fifo", rx_fifo_err, 1);
      pushes = 0;
      for (int k = 0; k < 15; k++) begin
        tick();
        if (brk_push) pushes++;
      end
      total++;
      if (pushes != 0) begin
        bad++;
        $display("FAIL R7: got %0d extra pushes expected 0", pushes);
      end
      check("R6 held while low", brk_flag, 1);
      rx_line = 1;
      step();
      check("R6 cleared at mark", brk_flag, 0);
      pop_tagged();
      check("R9 drained", rx_fifo_err, 0);
    end

    // R8 interrupted low period
    wlen = 0; par_en = 0; stop2 = 0;
    rx_line = 0;
    for (int k = 0; k < 5; k++) tick();
    rx_line = 1; step();
    rx_line = 0;
    for (int k = 0; k < 5; k++) tick();
    check("R8 count restarted", brk_flag, 0);
    tick(); tick();
    check("R8 full frame after restart", brk_flag, 1);
    rx_line = 1; step();
    pop_tagged();

    // R1 byte mode holding register
    thr_wr = 1;
    #1;
    check("R1 clears in write cycle", thre, 0);
    check("R3 temt low with byte", temt, 0);
    step();
    thr_wr = 0;
    #1;
    check("R1 stays low", thre, 0);
    thr_to_tsr = 1; tsr_busy = 1;
    step();
    thr_to_tsr = 0;
    #1;
    check("R1 set after move", thre, 1);
    check("R3 temt low while shifting", temt, 0);
    tsr_busy = 0;
    #1;
    check("R3 temt when idle", temt, 1);

    // R2 FIFO mode
    fifo_en = 1; tx_fifo_count = 5'd3;
    #1;
    check("R2 fifo holds bytes", thre, 0);
    check("R3 fifo nonempty", temt, 0);
    tx_fifo_count = 5'd0; tsr_busy = 1;
    #1;
    check("R2 fifo empty", thre, 1);
    check("R3 shifter busy", temt, 0);
    tsr_busy = 0;
    #1;
    check("R3 all empty", temt, 1);
    fifo_en = 0;
    step();

    // R9 error summary counting
    rx_push = 1; rx_push_err = 0; step();
    check("R9 untagged push", rx_fifo_err, 0);
    rx_push_err = 1; step(); step();
    rx_push = 0; rx_push_err = 0;
    check("R9 tagged pushes", rx_fifo_err, 1);
    rx_push = 1; rx_push_err = 1; rx_pop = 1; rx_pop_err = 1;
    step();
    rx_push = 0; rx_push_err = 0; rx_pop = 0; rx_pop_err = 0;
    check("R9 push+pop same cycle", rx_fifo_err, 1);
    pop_tagged();
    check("R9 one left", rx_fifo_err, 1);
    pop_tagged();
    check("R9 last tagged gone", rx_fifo_err, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule